// File: doc/BRIEF.md
# Memory Region Address Decoder

This block sits between a 32-bit bus master and the memories behind it. Each cycle it may receive a byte address, an access size and a read/write flag. It decides which memory the access belongs to and how the address folds into that memory's local space. The top byte of the address picks the region. Each region then applies its own mirroring rule, so addresses above the memory's real size wrap back into it. Finally, the offset is trimmed to the natural alignment of the access size.

The result is presented one clock later. It is a one-hot target select, a 25-bit local offset and a valid strobe. Accesses that hit no memory are routed to a null target. The null target returns zero to reads and discards writes, so the attached fabric never sees an undefined select. The boot ROM is guarded in two ways. Writes to it are sent to the null target. Reads beyond its 16 KiB contents are also sent to the null target.

Top module: `memdec_top`

## Requirements
- R1: The target is chosen by address bits [31:24]. The codes are 0x00 boot ROM, 0x02 external work RAM, 0x03 internal work RAM, 0x04 I/O, 0x05 palette RAM, 0x06 video RAM and 0x07 object RAM. On `out_sel` these are bits 1 through 7 in that order. Bit 0 is the null target and bit 8 is cartridge space. Exactly one bit of `out_sel` is set at all times.
- R2: Palette RAM and object RAM take the low 10 bits of the address as their offset. Internal work RAM takes the low 15 bits. External work RAM takes the low 18 bits.
- R3: Top-byte codes 0x08, 0x09, 0x0A and 0x0C all select cartridge space. Its offset is the low 25 bits of the address.
- R4: Video RAM first takes the low 17 bits of the address. If that value exceeds 0x18000, 0x8000 is subtracted from it, so 0x18000 itself is kept as is and no video RAM offset exceeds 0x18000.
- R5: In I/O space, an address whose low 16 bits are 0x8000 maps to offset 0x800. Every other I/O address keeps its low 11 bits.
- R6: A boot ROM read whose low 24 address bits are 0x4000 or more goes to the null target.
- R7: Every write with top byte 0x00 goes to the null target.
- R8: `req_width` is encoded as 0 for byte, 1 for halfword, 2 for word and 3 (reserved) for byte. Halfword accesses clear offset bit 0. Word accesses clear offset bits 1:0.
- R9: Any other top-byte value selects the null target. The null target's offset is the low 24 address bits, aligned as in R8; this also applies to the boot ROM cases of R6 and R7.
- R10: The select and offset for an accepted request appear exactly one clock after it. `out_valid` is high in that cycle exactly when `req_valid` was high in the cycle before.
- R11: In a cycle without `req_valid`, `out_sel` and `out_offset` keep their previous values.
- R12: Synchronous reset selects the null target, clears the offset and drives `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | 32 | Byte address |
| req_width | input | 2 | Access size code (see R8) |
| req_write | input | 1 | 1 for write, 0 for read |
| out_valid | output | 1 | Registered request strobe |
| out_sel | output | 9 | One-hot target select (see R1) |
| out_offset | output | 25 | Folded, aligned local offset |

## Verification
Some properties are checked by assertions on every cycle. These are: the select stays one-hot, the strobe has one-cycle latency, the outputs hold while idle, and ROM writes are diverted to the null target. Word accesses are always aligned. Video RAM offsets never pass the fold point. The special I/O address always lands on its slot, and every cartridge code selects the cartridge target. The exact folded values need the bench's reference model and its directed and random scenarios. Those values include each region's mirror wrap, the values on each side of the video fold, the ROM cutoff at 0x4000, the reserved width code and reset after traffic.

// File: rtl/memdec_pkg.sv
package memdec_pkg;

    localparam int ADDR_W = 32;
    localparam int OFF_W  = 25;
    localparam int N_TGT  = 9;
    localparam int PAGE_W = 8;
    localparam int LOW_W  = ADDR_W - PAGE_W;

    typedef enum logic [3:0] {
        TGT_NULL   = 4'd0,
        TGT_ROM    = 4'd1,
        TGT_EXTRAM = 4'd2,
        TGT_INTRAM = 4'd3,
        TGT_IO     = 4'd4,
        TGT_PAL    = 4'd5,
        TGT_VID    = 4'd6,
        TGT_OBJ    = 4'd7,
        TGT_CART   = 4'd8
    } tgt_e;

    typedef enum logic [1:0] {
        AW_BYTE = 2'd0,
        AW_HALF = 2'd1,
        AW_WORD = 2'd2,
        AW_RSVD = 2'd3
    } awidth_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [OFF_W-1:0] off;
    } route_t;

    localparam route_t ROUTE_RESET = '{tgt: TGT_NULL, off: '0};

    // Clears the low offset bits that the access size makes meaningless.
    function automatic logic [OFF_W-1:0] align_mask(awidth_e w);
        logic [OFF_W-1:0] m;
        m = '1;
        case (w)
            AW_WORD: m[1:0] = 2'b00;
            AW_HALF: m[0]   = 1'b0;
            default: m      = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/memdec_classify.sv
module memdec_classify
    import memdec_pkg::*;
#(
    parameter int ROM_BYTES = 32'h4000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output tgt_e              tgt
);
    localparam logic [LOW_W-1:0] ROM_LIM = LOW_W'(ROM_BYTES);

    logic [PAGE_W-1:0] page;
    logic [LOW_W-1:0]  low;

    assign page = addr[ADDR_W-1:LOW_W];
    assign low  = addr[LOW_W-1:0];

    always_comb begin
        case (page)
            8'h00:                      tgt = (wr || (low >= ROM_LIM)) ? TGT_NULL : TGT_ROM;
            8'h02:                      tgt = TGT_EXTRAM;
            8'h03:                      tgt = TGT_INTRAM;
            8'h04:                      tgt = TGT_IO;
            8'h05:                      tgt = TGT_PAL;
            8'h06:                      tgt = TGT_VID;
            8'h07:                      tgt = TGT_OBJ;
            8'h08, 8'h09, 8'h0A, 8'h0C: tgt = TGT_CART;
            default:                    tgt = TGT_NULL;
        endcase
    end
endmodule

// File: rtl/memdec_fold.sv
module memdec_fold
    import memdec_pkg::*;
#(
    parameter int EXT_MASK   = 32'h3FFFF,
    parameter int INT_MASK   = 32'h7FFF,
    parameter int SMALL_MASK = 32'h3FF,
    parameter int VID_SPAN   = 32'h20000,
    parameter int VID_KNEE   = 32'h18000,
    parameter int VID_SHIFT  = 32'h8000,
    parameter int IO_MAGIC   = 32'h8000,
    parameter int IO_SLOT    = 32'h800,
    parameter int IO_MASK    = 32'h7FF,
    parameter int CART_MASK  = 32'h1FFFFFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  tgt_e              tgt,
    input  awidth_e           width,
    output logic [OFF_W-1:0]  off
);
    localparam logic [OFF_W-1:0] M_EXT   = OFF_W'(EXT_MASK);
    localparam logic [OFF_W-1:0] M_INT   = OFF_W'(INT_MASK);
    localparam logic [OFF_W-1:0] M_SMALL = OFF_W'(SMALL_MASK);
    localparam logic [OFF_W-1:0] M_VID   = OFF_W'(VID_SPAN - 1);
    localparam logic [OFF_W-1:0] V_KNEE  = OFF_W'(VID_KNEE);
    localparam logic [OFF_W-1:0] V_SHIFT = OFF_W'(VID_SHIFT);
    localparam logic [15:0]      IO_KEY  = 16'(IO_MAGIC);
    localparam logic [OFF_W-1:0] IO_DST  = OFF_W'(IO_SLOT);
    localparam logic [OFF_W-1:0] M_IO    = OFF_W'(IO_MASK);
    localparam logic [OFF_W-1:0] M_CART  = OFF_W'(CART_MASK);

    logic [OFF_W-1:0] low_ofs;
    logic [OFF_W-1:0] vid_raw;
    logic [OFF_W-1:0] raw;

    assign low_ofs = OFF_W'(addr[LOW_W-1:0]);
    assign vid_raw = low_ofs & M_VID;

    always_comb begin
        case (tgt)
            TGT_EXTRAM:       raw = low_ofs & M_EXT;
            TGT_INTRAM:       raw = low_ofs & M_INT;
            TGT_PAL, TGT_OBJ: raw = low_ofs & M_SMALL;
            TGT_VID:          raw = (vid_raw > V_KNEE) ? (vid_raw - V_SHIFT) : vid_raw;
            TGT_IO:           raw = (addr[15:0] == IO_KEY) ? IO_DST : (low_ofs & M_IO);
            TGT_CART:         raw = addr[OFF_W-1:0] & M_CART;
            default:          raw = low_ofs;
        endcase
        off = raw & align_mask(width);
    end
endmodule

// File: rtl/memdec_outreg.sv
module memdec_outreg
    import memdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  route_t            in_route,
    output logic              out_valid,
    output logic [N_TGT-1:0]  out_sel,
    output logic [OFF_W-1:0]  out_off
);
    route_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q         <= ROUTE_RESET;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                q <= in_route;
            end
        end
    end

    for (genvar i = 0; i < N_TGT; i++) begin : g_sel
        assign out_sel[i] = (q.tgt == tgt_e'(i));
    end

    assign out_off = q.off;

    p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(out_sel) == 1);

    p_valid_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_sel) && $stable(out_off)));

    p_reset_r12: assert property (@(posedge clk)
        rst |=> (out_sel == N_TGT'(1) && !out_valid && out_off == '0));
endmodule

// File: rtl/memdec_top.sv
module memdec_top
    import memdec_pkg::*;
#(
    parameter int ROM_BYTES = 32'h4000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_width,
    input  logic               req_write,
    output logic               out_valid,
    output logic [N_TGT-1:0]   out_sel,
    output logic [OFF_W-1:0]   out_offset
);
    tgt_e             tgt;
    logic [OFF_W-1:0] off;
    route_t           route;

    memdec_classify #(.ROM_BYTES(ROM_BYTES)) u_classify (
        .addr (req_addr),
        .wr   (req_write),
        .tgt  (tgt)
    );

    memdec_fold u_fold (
        .addr  (req_addr),
        .tgt   (tgt),
        .width (awidth_e'(req_width)),
        .off   (off)
    );

    assign route = '{tgt: tgt, off: off};

    memdec_outreg u_outreg (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_route  (route),
        .out_valid (out_valid),
        .out_sel   (out_sel),
        .out_off   (out_offset)
    );

    p_romwp_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr[31:24] == 8'h00) |=> out_sel[0]);

    p_align_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_width == 2'd2) |=> (out_offset[1:0] == 2'b00));

    p_vid_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sel[6]) |-> (out_offset <= 25'h18000));

    p_io_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[31:24] == 8'h04 && req_addr[15:0] == 16'h8000)
        |=> (out_sel[4] && out_offset == 25'h800));

    p_cart_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_addr[31:24] == 8'h08 || req_addr[31:24] == 8'h09 ||
                       req_addr[31:24] == 8'h0A || req_addr[31:24] == 8'h0C))
        |=> out_sel[8]);
endmodule

// File: tb/tb_memdec_top.sv
module tb_memdec_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_width = '0;
    logic        req_write = 1'b0;
    logic        out_valid;
    logic [8:0]  out_sel;
    logic [24:0] out_offset;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    finished = 1'b0;
    logic        exp_valid = 1'b0;
    logic [8:0]  exp_sel   = 9'b1;
    logic [24:0] exp_off   = '0;
    string       exp_tag   = "R12";

    always #10 clk = ~clk;

    memdec_top dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_width(req_width), .req_write(req_write), .out_valid(out_valid),
        .out_sel(out_sel), .out_offset(out_offset)
    );

    // Behavioural reference: region by top byte, modulo wrap per memory size.
    function automatic void ref_route(input logic [31:0] a, input logic [1:0] w,
                                      input logic wr, output logic [8:0] sel,
                                      output logic [24:0] off);
        int hi, lo, o, idx;
        hi = int'(a[31:24]);
        lo = int'(a[23:0]);
        idx = 0;
        o = lo;
        case (hi)
            0: begin if (!wr && lo < 'h4000) idx = 1; end
            2: begin idx = 2; o = lo % 'h40000; end
            3: begin idx = 3; o = lo % 'h8000; end
            4: begin idx = 4; o = ((lo % 'h10000) == 'h8000) ? 'h800 : lo % 'h800; end
            5: begin idx = 5; o = lo % 'h400; end
            6: begin idx = 6; o = lo % 'h20000; if (o > 'h18000) o = o - 'h8000; end
            7: begin idx = 7; o = lo % 'h400; end
            8, 9, 10, 12: begin idx = 8; o = int'(a[24:0]); end
            default: idx = 0;
        endcase
        if (w == 2'd2) o = o - (o % 4);
        else if (w == 2'd1) o = o - (o % 2);
        sel = 9'b1 << idx;
        off = o[24:0];
    endfunction

    task automatic check_now();
        n_tests++;
        if (out_valid !== exp_valid || out_sel !== exp_sel || out_offset !== exp_off) begin
            n_fail++;
            $display("FAIL %s: got valid=%b sel=%b off=%h expected valid=%b sel=%b off=%h",
                     exp_tag, out_valid, out_sel, out_offset, exp_valid, exp_sel, exp_off);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] a, input logic [1:0] w,
                        input logic wr, input string tag);
        @(negedge clk);
        check_now();
        rst       = 1'b0;
        req_valid = v;
        req_addr  = a;
        req_width = w;
        req_write = wr;
        exp_valid = v;
        if (v) begin
            ref_route(a, w, wr, exp_sel, exp_off);
            exp_tag = tag;
        end else begin
            exp_tag = "R11";
        end
    endtask

    task automatic do_reset(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_now();
            rst       = 1'b1;
            req_valid = 1'b1;
            req_addr  = 32'h0600_0004;
            exp_valid = 1'b0;
            exp_sel   = 9'b1;
            exp_off   = '0;
            exp_tag   = "R12";
        end
    endtask

    initial begin
        do_reset(3);
        // R1 each region base
        step(1, 32'h0000_0100, 2'd2, 0, "R1");
        step(1, 32'h0200_0010, 2'd2, 0, "R1");
        step(1, 32'h0300_0020, 2'd2, 0, "R1");
        step(1, 32'h0400_0004, 2'd2, 0, "R1");
        step(1, 32'h0500_0008, 2'd1, 0, "R1");
        step(1, 32'h0600_0040, 2'd2, 0, "R1");
        step(1, 32'h0700_0030, 2'd2, 1, "R1");
        // R2 mirror wraps
        step(1, 32'h0213_4567, 2'd0, 0, "R2");
        step(1, 32'h03FF_FFFF, 2'd0, 1, "R2");
        step(1, 32'h0500_0BCD, 2'd0, 0, "R2");
        step(1, 32'h07AB_CDEF, 2'd0, 1, "R2");
        // R3 cartridge codes
        step(1, 32'h0812_3456, 2'd0, 0, "R3");
        step(1, 32'h0912_3456, 2'd0, 0, "R3");
        step(1, 32'h0BFF_FFFF, 2'd0, 0, "R9");
        step(1, 32'h0A00_0001, 2'd0, 1, "R3");
        step(1, 32'h0DFF_FFFF, 2'd0, 0, "R9");
        step(1, 32'h0CFF_FFFF, 2'd0, 0, "R3");
        // R4 video fold edges
        step(1, 32'h0601_8000, 2'd0, 0, "R4");
        step(1, 32'h0601_8001, 2'd0, 0, "R4");
        step(1, 32'h0601_FFFF, 2'd0, 1, "R4");
        step(1, 32'h0603_8004, 2'd2, 0, "R4");
        // R5 I/O slot
        step(1, 32'h0400_8000, 2'd0, 0, "R5");
        step(1, 32'h0412_8000, 2'd1, 1, "R5");
        step(1, 32'h0400_8001, 2'd0, 0, "R5");
        step(1, 32'h0400_0ABC, 2'd0, 0, "R5");
        // R6 ROM cutoff, R7 write protect
        step(1, 32'h0000_3FFF, 2'd0, 0, "R6");
        step(1, 32'h0000_4000, 2'd0, 0, "R6");
        step(1, 32'h0000_0010, 2'd2, 1, "R7");
        step(1, 32'h0000_0012, 2'd0, 0, "R7");
        // R8 widths
        step(1, 32'h0300_1237, 2'd0, 0, "R8");
        step(1, 32'h0300_1237, 2'd1, 0, "R8");
        step(1, 32'h0300_1237, 2'd2, 0, "R8");
        step(1, 32'h0300_1237, 2'd3, 0, "R8");
        // R9 unmapped, R11 hold
        step(1, 32'hFF12_3457, 2'd1, 0, "R9");
        step(0, 32'h0600_0000, 2'd0, 0, "R11");
        step(0, 32'h0412_8000, 2'd2, 1, "R11");
        step(1, 32'h0100_0003, 2'd0, 1, "R10");
        // R12 reset after traffic
        do_reset(2);
        // random traffic, R10 latency and all folds
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            logic [7:0]  pages [12];
            pages = '{8'h00, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06,
                      8'h07, 8'h08, 8'h09, 8'h0A, 8'h0C, 8'h0E};
            a = $urandom;
            a[31:24] = ($urandom % 8 == 0) ? 8'($urandom) : pages[$urandom % 12];
            if ($urandom % 6 == 0) a[15:0] = 16'h8000;
            step(1'($urandom % 4 != 0), a, 2'($urandom), 1'($urandom), "R10");
        end
        @(negedge clk);
        check_now();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule